// File: doc/BRIEF.md
# Four-Channel Sample Serializer

This block takes one 12-bit sample from each of four channels, all captured on the same strobe. It shifts the four samples out in lockstep on a fast bit clock. Each channel drives two lanes, or one lane when the narrow format is chosen. In the two-lane format a sample becomes a 16-bit word: the 12 data bits followed by four zero pad bits. This keeps the stream layout compatible with a wider 14-bit converter family. The word is split so that each lane carries every other bit. In the one-lane format the 12 data bits go out alone on one lane.

Each word comes with a frame marker that is high for the first half of the word, and with a data clock that changes level on every bit. An optional randomizer can scramble each sample before it is sent: every data bit above bit 0 is XORed with bit 0, and the receiver reverses this by applying the same XOR. An output-disable input forces every output low. Lane mode and randomizer enable are captured on the strobe and stay fixed for the whole word.

Top module: `quad_sample_serializer`

## Requirements
- R1: While reset is held, and after reset until the first strobe, lane_a, lane_b, frame and dclk are all 0.
- R2: In two-lane mode (one_lane=0 at the strobe) the serial word is {S[11:0], 4'b0000}, sent MSB first as 8 beats. On beat k (k=0..7), lane_a carries word bit 15-2k and lane_b carries word bit 14-2k. Beat 0 is on the outputs in the cycle after the clock edge that sees sample_valid high.
- R3: In two-lane mode, beats 6 and 7 carry only pad bits, so both lanes are 0 on those beats for any sample.
- R4: In one-lane mode (one_lane=1 at the strobe) the word lasts 12 beats. On beat k, lane_a carries S[11-k] and lane_b stays 0.
- R5: frame is 1 on beats 0 to 3 of a two-lane word and on beats 0 to 5 of a one-lane word, and 0 on the other beats.
- R6: dclk equals bit 0 of the beat index: it is 0 on beat 0 and changes level on every beat of a word.
- R7: Channel i takes sample_data[12i+11:12i] and drives lane_a[i] and lane_b[i]. All channels load on the same strobe and stay on the same beat.
- R8: When rand_en=1 at the strobe, S[11:1] = D[11:1] XOR D[0] and S[0] = D[0]. When rand_en=0, S = D. The pad bits are never scrambled.
- R9: While out_dis=1, every output is 0 in that same cycle. The word keeps advancing, so once out_dis falls the outputs show the beat that is due in that cycle.
- R10: Mode, randomizer enable and sample data are captured only on the strobe. A strobe in the middle of a word restarts at beat 0 with the new sample. After the last beat, with no new strobe, all outputs return to 0.
- R11: A strobe that arrives in the cycle showing a word's last beat makes the next word follow with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Strobe that loads a new sample set |
| sample_data | input | 48 | Four 12-bit samples, channel 0 in bits 11:0 |
| one_lane | input | 1 | 1 selects the 12-beat one-lane format |
| rand_en | input | 1 | 1 enables the bit-0 XOR randomizer |
| out_dis | input | 1 | 1 forces all outputs low |
| lane_a | output | 4 | First lane of each channel |
| lane_b | output | 4 | Second lane of each channel (two-lane mode only) |
| frame | output | 1 | High for the first half of each word |
| dclk | output | 1 | Data clock; changes level on every beat |

## Verification
Every output is a register, or a register gated by out_dis. So beat k of a word is due k+1 cycles after the negative edge on which the strobe is driven, and out_dis acts within the same cycle. The driver pushes one expected item for every cycle it drives, including idle, truncated and disabled cycles. The monitor pops one item 2 ns after each rising edge, so the queue order alone fixes the cycle in which each value is due. Round trips in both lane modes, with the randomizer on and off, are checked by rebuilding each beat from the requirements and comparing all 10 output bits.

// File: rtl/quad_sample_serializer.sv
module quad_sample_serializer #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 12,
  parameter int PAD_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_data,
  input  logic                       one_lane,
  input  logic                       rand_en,
  input  logic                       out_dis,
  output logic [NUM_CH-1:0]          lane_a,
  output logic [NUM_CH-1:0]          lane_b,
  output logic                       frame,
  output logic                       dclk
);
  localparam int WORD_W = SAMPLE_W + PAD_W;
  localparam int BEATS2 = WORD_W / 2;
  localparam int BEATS1 = SAMPLE_W;
  localparam int MAXB   = (BEATS1 > BEATS2) ? BEATS1 : BEATS2;
  localparam int CNT_W  = $clog2(MAXB);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(BEATS1 - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(BEATS2 - 1);
  localparam logic [CNT_W-1:0] HALF1 = CNT_W'(BEATS1 / 2);
  localparam logic [CNT_W-1:0] HALF2 = CNT_W'(BEATS2 / 2);

  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic              mode_q;
  logic [NUM_CH-1:0] raw_a, raw_b;
  logic              last_beat;

  assign last_beat = (cnt == (mode_q ? LAST1 : LAST2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      mode_q <= 1'b0;
    end else if (sample_valid) begin
      cnt    <= '0;
      active <= 1'b1;
      mode_q <= one_lane;
    end else if (active) begin
      if (last_beat) active <= 1'b0;
      else           cnt    <= cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [SAMPLE_W-1:0] d, s;
    logic [WORD_W-1:0]   sh;
    assign d = sample_data[i*SAMPLE_W +: SAMPLE_W];
    assign s = rand_en ? (d ^ {{(SAMPLE_W-1){d[0]}}, 1'b0}) : d;
    always_ff @(posedge clk) begin
      if (!rst_n)            sh <= '0;
      else if (sample_valid) sh <= {s, {PAD_W{1'b0}}};
      else if (active)       sh <= mode_q ? (sh << 1) : (sh << 2);
    end
    assign raw_a[i] = active & sh[WORD_W-1];
    assign raw_b[i] = active & ~mode_q & sh[WORD_W-2];
  end

  assign lane_a = out_dis ? '0 : raw_a;
  assign lane_b = out_dis ? '0 : raw_b;
  assign frame  = ~out_dis & active & (cnt < (mode_q ? HALF1 : HALF2));
  assign dclk   = ~out_dis & active & cnt[0];
endmodule

module serializer_checks #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 4,
  parameter int BEATS2 = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic              out_dis,
  input logic [NUM_CH-1:0] lane_a,
  input logic [NUM_CH-1:0] lane_b,
  input logic              frame,
  input logic              dclk,
  input logic              active,
  input logic              mode_q,
  input logic [CNT_W-1:0]  cnt
);
  AST_DIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |-> (lane_a == '0 && lane_b == '0 && !frame && !dclk)); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mode_q && cnt >= CNT_W'(BEATS2 - 2)) |-> (lane_a == '0 && lane_b == '0)); // R3
  AST_ONE_LANE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode_q) |-> (lane_b == '0)); // R4
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> (frame || out_dis)); // R5
  AST_DCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(sample_valid) && !out_dis && !$past(out_dis))
      |-> (dclk != $past(dclk))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (lane_a == '0 && lane_b == '0 && !frame && !dclk)); // R10
endmodule

bind quad_sample_serializer serializer_checks #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .BEATS2(BEATS2)
) u_checks (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .out_dis(out_dis),
  .lane_a(lane_a), .lane_b(lane_b), .frame(frame), .dclk(dclk),
  .active(active), .mode_q(mode_q), .cnt(cnt)
);

// File: tb/test_quad_sample_serializer.sv
`timescale 1ns/1ps
module test_quad_sample_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [47:0] sample_data = '0;
  logic        one_lane = 1'b0;
  logic        rand_en = 1'b0;
  logic        out_dis = 1'b0;
  logic [3:0]  lane_a, lane_b;
  logic        frame, dclk;

  int errors = 0;
  int checks = 0;

  logic [9:0] exp_q [$];
  string      tag_q [$];
  bit         dis_q [$];

  always #4 clk = ~clk;

  quad_sample_serializer i_quad_sample_serializer (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
    .one_lane(one_lane), .rand_en(rand_en), .out_dis(out_dis),
    .lane_a(lane_a), .lane_b(lane_b), .frame(frame), .dclk(dclk)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: one item per cycle, sampled 2 ns after the rising edge
  initial forever begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [9:0] e;
      string t;
      bit d;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      d = dis_q.pop_front();
      check({t, " R7 lanes"}, {2'b0, lane_a, lane_b}, {2'b0, e[9:2]});
      check(d ? "R9 frame" : "R5 frame", {9'b0, frame}, {9'b0, e[1]});
      check(d ? "R9 dclk" : "R6 dclk", {9'b0, dclk}, {9'b0, e[0]});
    end
  end

  // driver: called at a negedge, drives nb beats of one word
  task automatic send(input logic [47:0] data, input logic ol, input logic rnd,
                      input int nb, input int dis_lo, input int dis_hi, input string tag);
    logic [11:0] s [4];
    int beats;
    beats = ol ? 12 : 8;
    for (int c = 0; c < 4; c++) begin
      logic [11:0] d;
      d = data[c*12 +: 12];
      s[c] = rnd ? (d ^ {{11{d[0]}}, 1'b0}) : d;   // R8
    end
    for (int k = 0; k < nb; k++) begin
      logic [9:0] e;
      bit dis;
      string t;
      dis = (k >= dis_lo) && (k <= dis_hi);
      sample_valid = (k == 0);
      sample_data  = (k == 0) ? data : 48'($urandom) ^ {$urandom, 16'h0};
      one_lane     = (k == 0) ? ol : ~ol;   // later changes must be ignored (R10)
      rand_en      = (k == 0) ? rnd : ~rnd;
      out_dis      = dis;
      e = '0;
      if (!dis) begin
        for (int c = 0; c < 4; c++) begin
          logic [15:0] w;
          w = {s[c], 4'b0000};
          if (ol) begin
            e[6+c] = s[c][11-k];
            e[2+c] = 1'b0;
          end else begin
            e[6+c] = w[15-2*k];
            e[2+c] = w[14-2*k];
          end
        end
        e[1] = (k < beats/2);
        e[0] = k[0];
      end
      t = dis ? "R9" : (!ol && k >= 6) ? "R3" : tag;
      exp_q.push_back(e);
      tag_q.push_back(t);
      dis_q.push_back(dis);
      @(negedge clk);
    end
    sample_valid = 1'b0;
    out_dis = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      sample_valid = 1'b0;
      out_dis = 1'b0;
      exp_q.push_back('0);
      tag_q.push_back("R10 idle");
      dis_q.push_back(1'b0);
      @(negedge clk);
    end
  endtask

  function automatic logic [47:0] rnd48();
    return {16'($urandom), $urandom};
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {lane_a, lane_b, frame, dclk}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {lane_a, lane_b, frame, dclk}, '0);
    idle(2);

    // directed two-lane and one-lane words, distinct per channel
    send(48'hA5C_3F0_001_FFE, 1'b0, 1'b0, 8, 99, -1, "R2");
    idle(1);
    send(48'hA5C_3F0_001_FFE, 1'b1, 1'b0, 12, 99, -1, "R4");
    idle(1);
    // randomizer with bit 0 set and clear
    send(48'h001_FFF_555_AAA, 1'b0, 1'b1, 8, 99, -1, "R8 R2");
    send(48'h001_FFF_555_AAA, 1'b1, 1'b1, 12, 99, -1, "R8 R4 R11");
    idle(2);
    // mid-word restart, then back to idle
    send(48'hFFF_FFF_FFF_FFF, 1'b1, 1'b0, 3, 99, -1, "R10 R4");
    send(48'h123_456_789_ABC, 1'b0, 1'b0, 8, 99, -1, "R10 R2");
    idle(3);
    // output disable within a word
    send(48'hFFF_FFF_FFF_FFF, 1'b0, 1'b0, 8, 2, 4, "R2");
    send(48'hFFF_FFF_FFF_FFF, 1'b1, 1'b0, 12, 0, 0, "R4");
    idle(2);

    // random round trips in all four mode combinations, back to back
    for (int n = 0; n < 120; n++) begin
      logic ol, rd;
      ol = n[0];
      rd = n[1];
      send(rnd48(), ol, rd, ol ? 12 : 8, 99, -1,
           rd ? (ol ? "R8 R4 R11" : "R8 R2 R11") : (ol ? "R4 R11" : "R2 R11"));
      if (n % 7 == 3) idle(1);
    end
    idle(3);

    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule